// File: doc/BRIEF.md
# Branch and Next-PC Unit

This unit decides where a 32-bit processor fetches next. Each request carries the address of the current instruction, the instruction word, and the two source-register values the register file has read for it. The unit classifies the word as one of the control-flow forms (two-register equality tests, sign tests of the first source register, absolute jumps with or without a return link, a jump through a register) or as an ordinary instruction. It returns the next fetch address, a flag saying whether control flow was redirected, and a request to write a return address.

Requests arrive on a valid/ready stream and leave on a second valid/ready stream. The decision itself is combinational; one output register stage (selectable by parameter) holds the result. A request is accepted in any cycle where `in_valid` and `in_ready` are both high. A result is consumed in any cycle where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, every output field stays frozen and no new request is accepted. A consumer that keeps `out_ready` high sees one result per cycle.

Top module: `nextpc_unit`

## Requirements

In these requirements, `op` is instruction bits 31:26, `sf` is the first source field (bits 25:21), `tf` is the second source field (bits 20:16), `fn` is bits 5:0, `off` is bits 15:0 and `tgt` is bits 25:0. "Sequential" means `in_pc`+4.

- R1: While `rst_n` is low, `out_valid` is 0.
- R2: For `op`=0x04 the flow is redirected when the two register values are equal. For `op`=0x05 it is redirected when they differ.
- R3: A redirected conditional branch targets the sequential address plus `off` sign-extended and shifted left by 2. This also holds for negative offsets. A branch that is not taken yields the sequential address.
- R4: For `op`=0x01, `tf`=0 redirects when the first register value is negative, and `tf`=1 redirects when it is zero or positive. Any other `tf` is treated as an ordinary instruction.
- R5: `op`=0x06 redirects when the first register value is ≤ 0, and `op`=0x07 redirects when it is > 0. Both do so only when `tf`=0. With a nonzero `tf` they are treated as ordinary instructions.
- R6: `op`=0x02 always redirects to bits 31:28 of the sequential address, followed by `tgt`, followed by two zero bits.
- R7: `op`=0x03 redirects like R6. It also asserts `out_link_we` with `out_link_idx`=31 and `out_link_val`=`in_pc`+8. No other instruction asserts `out_link_we`.
- R8: `op`=0x00 with `fn`=0x08 redirects to the first register value.
- R9: Any other instruction gives `out_taken`=0 and `out_next_pc` equal to the sequential address.
- R10: `in_ready` is high exactly when no result is pending or the pending result is being consumed. An accepted request appears on the output the following cycle. A stalled result stays unchanged.
- R11: The sign tests treat the first register value as two's complement, so 0x80000000 is negative and 0x7FFFFFFF is positive.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_pc | input | 32 | Address of the current instruction |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the first source register |
| in_rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 32 | Next fetch address |
| out_taken | output | 1 | Control flow redirected |
| out_link_we | output | 1 | Return-address write requested |
| out_link_idx | output | 5 | Destination register of the link write |
| out_link_val | output | 32 | Return address to write |

## Verification

The hardest case to reach from the ports is a result held under back-pressure while the next request, often of a different instruction kind, waits at the input. In that case the frozen output and the withheld `in_ready` must both be right in the same cycle. The bench produces this by holding `out_ready` low at random for about a quarter of the cycles while requests stream in back to back. Its cycle model predicts `in_ready`, `out_valid` and every result field in every cycle.

A directed pass also covers the edges of the decision:
- register values of zero, -1 and 0x80000000 for the sign tests;
- a negative branch offset;
- a fetch address whose upper nibble changes after adding 4;
- the nonzero `tf` forms that must fall through.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned OFF_W   = 16;
  localparam int unsigned TGT_W   = 26;

  localparam logic [OPC_W-1:0] OPC_RFMT     = 6'h00;
  localparam logic [OPC_W-1:0] OPC_SIGNGRP  = 6'h01;
  localparam logic [OPC_W-1:0] OPC_JUMP     = 6'h02;
  localparam logic [OPC_W-1:0] OPC_JUMPLINK = 6'h03;
  localparam logic [OPC_W-1:0] OPC_EQ       = 6'h04;
  localparam logic [OPC_W-1:0] OPC_NE       = 6'h05;
  localparam logic [OPC_W-1:0] OPC_LEZ      = 6'h06;
  localparam logic [OPC_W-1:0] OPC_GTZ      = 6'h07;

  localparam logic [5:0]       FN_REGJUMP   = 6'h08;
  localparam logic [FLD_W-1:0] SUB_LTZ      = 5'd0;
  localparam logic [FLD_W-1:0] SUB_GEZ      = 5'd1;

  typedef enum logic [3:0] {
    CF_NONE,
    CF_EQ,
    CF_NE,
    CF_LTZ,
    CF_GEZ,
    CF_LEZ,
    CF_GTZ,
    CF_JUMP,
    CF_JLINK,
    CF_JREG
  } cf_kind_e;

  typedef struct packed {
    cf_kind_e         kind;
    logic [OFF_W-1:0] off;
    logic [TGT_W-1:0] tgt;
  } cf_dec_t;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
  import nextpc_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output cf_dec_t            dec
);

  logic [OPC_W-1:0] opc;
  logic [FLD_W-1:0] tfield;
  logic [5:0]       fn;

  assign opc    = instr[31:26];
  assign tfield = instr[20:16];
  assign fn     = instr[5:0];

  always_comb begin
    dec.off  = instr[OFF_W-1:0];
    dec.tgt  = instr[TGT_W-1:0];
    dec.kind = CF_NONE;
    unique case (opc)
      OPC_EQ:       dec.kind = CF_EQ;
      OPC_NE:       dec.kind = CF_NE;
      OPC_JUMP:     dec.kind = CF_JUMP;
      OPC_JUMPLINK: dec.kind = CF_JLINK;
      OPC_LEZ:      dec.kind = (tfield == '0) ? CF_LEZ : CF_NONE;
      OPC_GTZ:      dec.kind = (tfield == '0) ? CF_GTZ : CF_NONE;
      OPC_SIGNGRP: begin
        if (tfield == SUB_LTZ)      dec.kind = CF_LTZ;
        else if (tfield == SUB_GEZ) dec.kind = CF_GEZ;
        else                        dec.kind = CF_NONE;
      end
      OPC_RFMT:     dec.kind = (fn == FN_REGJUMP) ? CF_JREG : CF_NONE;
      default:      dec.kind = CF_NONE;
    endcase
  end

endmodule

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cf_kind_e        kind,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            taken
);

  logic is_neg;
  logic is_zero;
  logic is_same;

  assign is_neg  = rs_val[XLEN-1];
  assign is_zero = (rs_val == '0);
  assign is_same = (rs_val == rt_val);

  always_comb begin
    unique case (kind)
      CF_EQ:    taken = is_same;
      CF_NE:    taken = !is_same;
      CF_LTZ:   taken = is_neg;
      CF_GEZ:   taken = !is_neg;
      CF_LEZ:   taken = is_neg || is_zero;
      CF_GTZ:   taken = !is_neg && !is_zero;
      CF_JUMP,
      CF_JLINK,
      CF_JREG:  taken = 1'b1;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned INSTR_BYTES = 4
) (
  input  logic [XLEN-1:0] pc,
  input  cf_dec_t         dec,
  input  logic [XLEN-1:0] rs_val,
  input  logic            taken,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] link_val
);

  localparam int unsigned SHIFT   = $clog2(INSTR_BYTES);
  localparam int unsigned REGION  = TGT_W + SHIFT;
  localparam int unsigned EXT_W   = XLEN - OFF_W - SHIFT;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] br_disp;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;

  assign seq_pc   = pc + XLEN'(INSTR_BYTES);
  assign link_val = pc + XLEN'(2 * INSTR_BYTES);
  assign br_disp  = {{EXT_W{dec.off[OFF_W-1]}}, dec.off, {SHIFT{1'b0}}};
  assign br_pc    = seq_pc + br_disp;
  assign jmp_pc   = {seq_pc[XLEN-1:REGION], dec.tgt, {SHIFT{1'b0}}};

  always_comb begin
    next_pc = seq_pc;
    if (taken) begin
      unique case (dec.kind)
        CF_JUMP, CF_JLINK: next_pc = jmp_pc;
        CF_JREG:           next_pc = rs_val;
        default:           next_pc = br_pc;
      endcase
    end
  end

endmodule

// File: rtl/nextpc_stage.sv
module nextpc_stage #(
  parameter int unsigned W          = 8,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  generate
    if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] data_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else if (in_ready) begin
          vld_q <= in_valid;
          if (in_valid) data_q <= in_data;
        end
      end
    end else begin : g_thru
      assign in_ready  = out_ready;
      assign out_valid = in_valid && rst_n;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int unsigned XLEN        = 32,
  parameter int unsigned REG_AW      = 5,
  parameter int unsigned LINK_REG    = 31,
  parameter int unsigned INSTR_BYTES = 4,
  parameter bit          OUT_REG     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_instr,
  input  logic [XLEN-1:0]   in_rs_val,
  input  logic [XLEN-1:0]   in_rt_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_link_we,
  output logic [REG_AW-1:0] out_link_idx,
  output logic [XLEN-1:0]   out_link_val
);

  localparam int unsigned PAY_W = 2 * XLEN + 2;

  cf_dec_t         dec;
  logic            taken;
  logic [XLEN-1:0] next_pc;
  logic [XLEN-1:0] link_val;
  logic            link_we;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  nextpc_decode u_dec (
    .instr (in_instr[INSTR_W-1:0]),
    .dec   (dec)
  );

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .kind   (dec.kind),
    .rs_val (in_rs_val),
    .rt_val (in_rt_val),
    .taken  (taken)
  );

  nextpc_target #(.XLEN(XLEN), .INSTR_BYTES(INSTR_BYTES)) u_tgt (
    .pc       (in_pc),
    .dec      (dec),
    .rs_val   (in_rs_val),
    .taken    (taken),
    .next_pc  (next_pc),
    .link_val (link_val)
  );

  assign link_we = (dec.kind == CF_JLINK);
  assign pay_in  = {next_pc, taken, link_we, link_val};

  nextpc_stage #(.W(PAY_W), .REGISTERED(OUT_REG)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {out_next_pc, out_taken, out_link_we, out_link_val} = pay_out;
  assign out_link_idx = out_link_we ? REG_AW'(LINK_REG) : '0;

endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_pc,
  input logic [31:0] in_instr,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_next_pc,
  input logic        out_taken,
  input logic        out_link_we,
  input logic [4:0]  out_link_idx,
  input logic [31:0] out_link_val
);

  // R10: an accepted request is presented on the next cycle
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10: a stalled result keeps every field
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) &&
      $stable(out_taken) && $stable(out_link_we) && $stable(out_link_val));

  // R7: link write goes to register 31 with the address two words on
  p_link_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !out_link_we ||
      (out_taken && out_link_idx == 5'd31 && out_link_val == $past(in_pc) + 32'd8));

  // R9: without a redirect the result is the sequential address
  p_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_taken || out_next_pc == $past(in_pc) + 32'd4);

  // R6: plain jump keeps the upper nibble of the sequential address
  p_jump_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_instr[31:26] == 6'h02 |=>
      out_taken && !out_link_we &&
      out_next_pc == {$past(in_pc + 32'd4) >> 28, $past(in_instr[25:0]), 2'b00});

endmodule

bind nextpc_unit nextpc_unit_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_pc        (in_pc),
  .in_instr     (in_instr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_next_pc  (out_next_pc),
  .out_taken    (out_taken),
  .out_link_we  (out_link_we),
  .out_link_idx (out_link_idx),
  .out_link_val (out_link_val)
);

// File: tb/nextpc_unit_tb_top.sv
`timescale 1ns/1ps
module nextpc_unit_tb_top;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [31:0] in_pc, in_instr, in_rs_val, in_rt_val;
  logic [31:0] out_next_pc, out_link_val;
  logic        out_taken, out_link_we;
  logic [4:0]  out_link_idx;

  always #10 clk = ~clk;

  nextpc_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_instr(in_instr), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_next_pc(out_next_pc), .out_taken(out_taken), .out_link_we(out_link_we),
    .out_link_idx(out_link_idx), .out_link_val(out_link_val)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input logic [15:0] imm);
    return {op[5:0], rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] enc_j(input int op, input logic [25:0] t);
    return {op[5:0], t};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, input int fn);
    return {6'd0, rs[4:0], 15'd0, fn[5:0]};
  endfunction

  // Behavioural reference taken from the requirements
  function automatic void ref_calc(input logic [31:0] pc, input logic [31:0] instr,
                                   input logic [31:0] a, input logic [31:0] b,
                                   output logic [31:0] npc, output logic tk,
                                   output logic lw, output logic [31:0] lv, output string tag);
    int op, tf, fn, sa, off;
    logic [31:0] seq;
    op  = int'(instr[31:26]);
    tf  = int'(instr[20:16]);
    fn  = int'(instr[5:0]);
    sa  = $signed(a);
    off = $signed(instr[15:0]);
    seq = pc + 32'd4;
    npc = seq; tk = 0; lw = 0; lv = pc + 32'd8; tag = "R9";
    case (op)
      4: begin tag = "R2"; tk = (a == b); end
      5: begin tag = "R2"; tk = (a != b); end
      1: if (tf == 0) begin tag = "R4/R11"; tk = (sa < 0); end
         else if (tf == 1) begin tag = "R4/R11"; tk = (sa >= 0); end
      6: if (tf == 0) begin tag = "R5/R11"; tk = (sa <= 0); end
      7: if (tf == 0) begin tag = "R5/R11"; tk = (sa > 0); end
      2: begin tag = "R6"; tk = 1; npc = {seq[31:28], instr[25:0], 2'b00}; end
      3: begin tag = "R7"; tk = 1; lw = 1; npc = {seq[31:28], instr[25:0], 2'b00}; end
      0: if (fn == 8) begin tag = "R8"; tk = 1; npc = a; end
      default: ;
    endcase
    if (tk && op >= 1 && op <= 7 && op != 2 && op != 3) begin
      npc = seq + 32'(off * 4);
      tag = {tag, "/R3"};
    end
  endfunction

  // Cycle model of the output stage
  logic        m_vld, acc_q;
  logic [31:0] m_npc, m_lv;
  logic        m_tk, m_lw;
  string       m_tag;
  logic [31:0] r_npc, r_lv;
  logic        r_tk, r_lw;
  string       r_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= 0;
      acc_q <= 0;
    end else begin
      acc_q <= in_valid && (!m_vld || out_ready);
      if (!m_vld || out_ready) begin
        m_vld <= in_valid;
        if (in_valid) begin
          ref_calc(in_pc, in_instr, in_rs_val, in_rt_val, r_npc, r_tk, r_lw, r_lv, r_tag);
          m_npc <= r_npc; m_tk <= r_tk; m_lw <= r_lw; m_lv <= r_lv; m_tag <= r_tag;
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  txn_t q[$];

  function automatic logic [31:0] pick_val(input int k);
    case (k % 8)
      0: return 32'd0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      4: return 32'd1;
      5: return 32'd5;
      6: return 32'd5;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    int idx;
    int cyc;
    bit rnd_phase;
    rst_n = 0; in_valid = 0; out_ready = 0;
    in_pc = 0; in_instr = 0; in_rs_val = 0; in_rt_val = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    end
    rst_n = 1;

    // Directed cases
    q.push_back('{32'h0040_0100, enc_i(4, 1, 2, 16'h0003), 32'd7, 32'd7});
    q.push_back('{32'h0040_0100, enc_i(4, 1, 2, 16'h0003), 32'd7, 32'd8});
    q.push_back('{32'h0040_0200, enc_i(5, 1, 2, 16'hFFFE), 32'd7, 32'd8});
    q.push_back('{32'h0040_0200, enc_i(5, 1, 2, 16'hFFFE), 32'd9, 32'd9});
    q.push_back('{32'h0040_0300, enc_i(1, 3, 0, 16'h0010), 32'h8000_0000, 0});
    q.push_back('{32'h0040_0300, enc_i(1, 3, 0, 16'h0010), 32'h7FFF_FFFF, 0});
    q.push_back('{32'h0040_0300, enc_i(1, 3, 1, 16'h8000), 32'd0, 0});
    q.push_back('{32'h0040_0300, enc_i(1, 3, 1, 16'h8000), 32'hFFFF_FFFF, 0});
    q.push_back('{32'h0040_0300, enc_i(1, 3, 2, 16'h0010), 32'd0, 0});
    q.push_back('{32'h0040_0400, enc_i(6, 4, 0, 16'h0020), 32'd0, 0});
    q.push_back('{32'h0040_0400, enc_i(6, 4, 0, 16'h0020), 32'd1, 0});
    q.push_back('{32'h0040_0400, enc_i(6, 4, 3, 16'h0020), 32'd0, 0});
    q.push_back('{32'h0040_0500, enc_i(7, 4, 0, 16'h0020), 32'h7FFF_FFFF, 0});
    q.push_back('{32'h0040_0500, enc_i(7, 4, 0, 16'h0020), 32'h8000_0000, 0});
    q.push_back('{32'h0040_0500, enc_i(7, 4, 1, 16'h0020), 32'd5, 0});
    q.push_back('{32'hEFFF_FFFC, enc_j(2, 26'h3AB_CDEF), 0, 0});
    q.push_back('{32'h0040_0600, enc_j(2, 26'h000_0040), 0, 0});
    q.push_back('{32'h0040_0700, enc_j(3, 26'h123_4567), 0, 0});
    q.push_back('{32'h0040_0800, enc_r(9, 8), 32'hDECA_FE00, 0});
    q.push_back('{32'h0040_0900, enc_r(9, 32), 32'hDECA_FE00, 0});
    q.push_back('{32'h0040_0A00, enc_i(35, 1, 2, 16'h0004), 0, 0});
    q.push_back('{32'hFFFF_FFFC, enc_i(8, 1, 2, 16'h0004), 0, 0});
    for (int i = 0; i < 400; i++) begin
      int sel, op, rt;
      logic [31:0] w;
      sel = $urandom_range(0, 10);
      rt  = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 3) : 0;
      case (sel)
        8:  w = enc_r($urandom_range(0, 31), 8);
        9:  w = enc_r($urandom_range(0, 31), $urandom_range(0, 63));
        10: w = enc_i(35, 1, 2, 16'($urandom));
        default: begin
          op = sel;
          if (op == 0) op = 4;
          if (op == 2 || op == 3) w = enc_j(op, 26'($urandom));
          else w = enc_i(op, $urandom_range(0, 31), (op == 4 || op == 5) ? $urandom_range(0, 31) : rt, 16'($urandom));
        end
      endcase
      q.push_back('{$urandom & 32'hFFFF_FFFC, w, pick_val($urandom), pick_val($urandom)});
    end

    idx = 0; cyc = 0; rnd_phase = 0;
    while ((idx < q.size() || m_vld) && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      if (idx >= 22) rnd_phase = 1;
      // compare to the cycle model
      chk("R10", "in_ready", {31'd0, in_ready}, {31'd0, (!m_vld || out_ready)});
      chk("R10", "out_valid", {31'd0, out_valid}, {31'd0, m_vld});
      if (m_vld) begin
        chk(m_tag, "next_pc", out_next_pc, m_npc);
        chk(m_tag, "taken", {31'd0, out_taken}, {31'd0, m_tk});
        chk("R7", "link_we", {31'd0, out_link_we}, {31'd0, m_lw});
        if (m_lw) begin
          chk("R7", "link_idx", {27'd0, out_link_idx}, 32'd31);
          chk("R7", "link_val", out_link_val, m_lv);
        end
      end
      if (in_valid && acc_q) idx++;
      // drive next cycle
      out_ready = rnd_phase ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (in_valid && !acc_q) begin
        in_valid = 1;
      end else if (idx < q.size() && (!rnd_phase || $urandom_range(0, 4) != 0)) begin
        in_valid  = 1;
        in_pc     = q[idx].pc;
        in_instr  = q[idx].instr;
        in_rs_val = q[idx].a;
        in_rt_val = q[idx].b;
      end else begin
        in_valid = 0;
      end
    end
    if (idx < q.size()) begin
      errors++;
      $display("FAIL R10 drain: actual=%0d expected=%0d", idx, q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule